// File: doc/BRIEF.md
# VMEbus Requester with Programmable Release Policies

This block is the requesting side of a board's connection to a shared VMEbus-style backplane. When local logic needs the bus, or when software forces it to, the block drives one of four bus-request lines. It waits for the grant, asserts busy for as long as it is master, and hands the bus back according to a policy chosen in an 8-bit configuration register. The arbiter and the data-transfer handshake sit outside this block.

Three release policies are available. The first hands the bus back after every completed local cycle. The second keeps the bus until some other board raises a request. The third never gives it up while a hold bit is set. A separate hold-off option makes the block wait after a release: the request line of its own level must be seen low for a minimum time, and then a further drive delay must pass, before the block requests again. Both minimums are given in picoseconds and turned into clock cycles from the clock period. A newly written request level only takes effect at the next release. The readback shows the level in use, and it also shows whether the board currently owns the bus.

Top module: `bus_requester_top`

## Requirements
- R1: After synchronous reset, `br_out` is 0, `bbsy` is 0 and `have_bus` is 0. `cfg_rdata` reads 0x03, meaning active level 3 and every other bit clear.
- R2: When the block is idle and either `loc_req` or the stay bit (bit 7) is set, the block drives exactly one request line: bit n of `br_out` for active level n. The request holds until `bg_in` is sampled high. On the next cycle `bbsy` and `have_bus` are 1 and `br_out` is 0.
- R3: Bits 1:0 of a configuration write hold a pending level. That level becomes active only when the block next releases mastership. Until then, `cfg_rdata[1:0]` returns the active level.
- R4: When bits 7 and 3 are clear and bit 4 (release-when-done) is set, `loc_done` sampled high while master makes `bbsy` fall on the following cycle. In this mode `br_others` has no effect.
- R5: When bits 7, 4 and 3 are clear, the block stays master until any bit of `br_others` is sampled high, and then releases on the next cycle. In this mode `loc_done` has no effect.
- R6: Bit 3 (never-release) keeps the block master regardless of `loc_done` or `br_others`. Bit 3 does not on its own start a request.
- R7: Bit 7 (stay-on-bus) starts a request without `loc_req`. Mastership is held until both bit 7 and bit 3 are clear, after which the bit-4 policy applies.
- R8: If bit 5 is set when the bus is released, no request is driven until two conditions have been met in order. First, `br_others[active level]` must be low for NEG_CYC consecutive cycles, where NEG_CYC = ceil(150 ns / clock period). Then DRV_CYC further cycles must pass, where DRV_CYC = ceil(200 ns / clock period). If bit 5 is clear, a held `loc_req` is re-driven 2 cycles after `bbsy` falls.
- R9: `cfg_rdata` bit 6 equals `have_bus`. Bit 2 reads 0. Bits 3, 4, 5 and 7 read back as written.
- R10: At most one `br_out` bit is high at a time, and no `br_out` bit is high while `bbsy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback with active level and mastership status |
| loc_req | input | 1 | Local logic needs the bus |
| loc_done | input | 1 | Local bus cycle completed (one-cycle pulse) |
| bg_in | input | 1 | Bus grant arriving for this board |
| br_others | input | NUM_LEVELS | Request lines as driven by other boards |
| br_out | output | NUM_LEVELS | Request lines driven by this board |
| bbsy | output | 1 | Bus busy, high while master |
| have_bus | output | 1 | Mastership status |

## Verification
The hardest situation to reach from the ports is the hold-off window. It needs a release with bit 5 set, a local request still pending, and another board holding the same request level high across the release. The bench creates this by keeping `br_others[0]` high through a release-when-done cycle, which that policy ignores. It then holds the line for a long stretch, drops it, and counts cycles until `br_out` rises, comparing the count with the window derived from the clock period. Level lag is reached by sweeping every level through a write, a full gain and release, and a fresh request.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_MASTER  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_HOLDOFF = 3'd4
  } req_state_t;

  typedef struct packed {
    logic stay;   // keep requesting / hold mastership
    logic wneg;   // wait for line negation before re-request
    logic rwd;    // release after each completed cycle
    logic never;  // never release while set
  } req_policy_t;

  // configuration bit positions (fixed register layout)
  localparam int BIT_NEVER = 3;
  localparam int BIT_RWD   = 4;
  localparam int BIT_WNEG  = 5;
  localparam int BIT_HAVE  = 6;
  localparam int BIT_STAY  = 7;

  function automatic int cycles_for(input int ps, input int period_ps);
    return (ps + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/req_cfg_reg.sv
module req_cfg_reg
  import bus_req_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             apply_lvl,
  input  logic             have_bus,
  output req_policy_t      policy,
  output logic [LVL_W-1:0] active_lvl,
  output logic [7:0]       rd_data
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);

  logic [LVL_W-1:0] pend_lvl;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[BIT_HAVE], wr_data[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      policy     <= '0;
      pend_lvl   <= TOP_LVL;
      active_lvl <= TOP_LVL;
    end else begin
      if (wr_en) begin
        policy.stay  <= wr_data[BIT_STAY];
        policy.wneg  <= wr_data[BIT_WNEG];
        policy.rwd   <= wr_data[BIT_RWD];
        policy.never <= wr_data[BIT_NEVER];
        pend_lvl     <= wr_data[LVL_W-1:0];
      end
      if (apply_lvl) begin
        active_lvl <= (wr_en) ? wr_data[LVL_W-1:0] : pend_lvl;
      end
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[LVL_W-1:0] = active_lvl;
    rd_data[BIT_NEVER] = policy.never;
    rd_data[BIT_RWD]   = policy.rwd;
    rd_data[BIT_WNEG]  = policy.wneg;
    rd_data[BIT_HAVE]  = have_bus;
    rd_data[BIT_STAY]  = policy.stay;
  end

endmodule

// File: rtl/req_holdoff_timer.sv
module req_holdoff_timer #(
  parameter int NEG_CYC = 19,
  parameter int DRV_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic line_in,
  output logic done
);

  localparam int MAXC = (NEG_CYC > DRV_CYC) ? NEG_CYC : DRV_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] NEG_LAST = CW'(NEG_CYC - 1);
  localparam logic [CW-1:0] DRV_LAST = CW'(DRV_CYC - 1);

  logic [CW-1:0] cnt;
  logic          drive_phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt         <= '0;
      drive_phase <= 1'b0;
    end else if (!drive_phase) begin
      if (line_in) begin
        cnt <= '0;
      end else if (cnt == NEG_LAST) begin
        cnt         <= '0;
        drive_phase <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (cnt != DRV_LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && drive_phase && (cnt == DRV_LAST);

endmodule

// File: rtl/req_fsm.sv
module req_fsm
  import bus_req_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  want,
  input  req_policy_t           policy,
  input  logic [LVL_W-1:0]      active_lvl,
  input  logic                  grant_in,
  input  logic                  other_req,
  input  logic                  cycle_done,
  input  logic                  holdoff_done,
  output req_state_t            state,
  output logic                  apply_lvl,
  output logic [NUM_LEVELS-1:0] br_out,
  output logic                  bbsy,
  output logic                  have_bus
);

  req_state_t            nxt;
  logic [NUM_LEVELS-1:0] lvl_onehot;
  logic                  release_now;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_dec
    assign lvl_onehot[g] = (active_lvl == LVL_W'(g));
  end

  always_comb begin
    if (policy.stay || policy.never) release_now = 1'b0;
    else if (policy.rwd)             release_now = cycle_done;
    else                             release_now = other_req;
  end

  always_comb begin
    nxt       = state;
    apply_lvl = 1'b0;
    unique case (state)
      ST_IDLE:    if (want) nxt = ST_REQUEST;
      ST_REQUEST: if (grant_in) nxt = ST_MASTER;
      ST_MASTER: begin
        if (release_now) begin
          nxt       = ST_RELEASE;
          apply_lvl = 1'b1;
        end
      end
      ST_RELEASE: nxt = policy.wneg ? ST_HOLDOFF : ST_IDLE;
      ST_HOLDOFF: if (holdoff_done) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      br_out   <= '0;
      bbsy     <= 1'b0;
      have_bus <= 1'b0;
    end else begin
      state    <= nxt;
      br_out   <= (nxt == ST_REQUEST) ? lvl_onehot : '0;
      bbsy     <= (nxt == ST_MASTER);
      have_bus <= (nxt == ST_MASTER);
    end
  end

endmodule

// File: rtl/bus_requester_top.sv
module bus_requester_top
  import bus_req_pkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int NEG_MIN_PS    = 150000,
  parameter int DRV_MIN_PS    = 200000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic                  loc_req,
  input  logic                  loc_done,
  input  logic                  bg_in,
  input  logic [NUM_LEVELS-1:0] br_others,
  output logic [NUM_LEVELS-1:0] br_out,
  output logic                  bbsy,
  output logic                  have_bus
);

  localparam int LVL_W   = $clog2(NUM_LEVELS);
  localparam int NEG_CYC = cycles_for(NEG_MIN_PS, CLK_PERIOD_PS);
  localparam int DRV_CYC = cycles_for(DRV_MIN_PS, CLK_PERIOD_PS);

  req_policy_t      policy_w;
  logic [LVL_W-1:0] active_lvl_w;
  logic             apply_w;
  logic             hold_done_w;
  req_state_t       state_w;

  req_cfg_reg #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_data   (cfg_wdata),
    .apply_lvl (apply_w),
    .have_bus  (have_bus),
    .policy    (policy_w),
    .active_lvl(active_lvl_w),
    .rd_data   (cfg_rdata)
  );

  req_holdoff_timer #(.NEG_CYC(NEG_CYC), .DRV_CYC(DRV_CYC)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .run    (state_w == ST_HOLDOFF),
    .line_in(br_others[active_lvl_w]),
    .done   (hold_done_w)
  );

  req_fsm #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .want        (loc_req | policy_w.stay),
    .policy      (policy_w),
    .active_lvl  (active_lvl_w),
    .grant_in    (bg_in),
    .other_req   (|br_others),
    .cycle_done  (loc_done),
    .holdoff_done(hold_done_w),
    .state       (state_w),
    .apply_lvl   (apply_w),
    .br_out      (br_out),
    .bbsy        (bbsy),
    .have_bus    (have_bus)
  );

endmodule

// File: rtl/bus_requester_checker.sv
module bus_requester_checker #(
  parameter int NUM_LEVELS = 4,
  parameter int QUIET_CYC  = 44
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LEVELS-1:0] br_out,
  input logic                  bbsy,
  input logic                  bg_in,
  input logic [NUM_LEVELS-1:0] br_others,
  input logic                  loc_done,
  input logic                  never_i,
  input logic                  stay_i,
  input logic                  rwd_i,
  input logic                  wneg_i
);

  localparam int QW = $clog2(QUIET_CYC + 1);

  logic          bbsy_d;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      bbsy_d <= 1'b0;
      quiet  <= '0;
    end else begin
      bbsy_d <= bbsy;
      if (bbsy_d && !bbsy && wneg_i) quiet <= QW'(QUIET_CYC);
      else if (quiet != '0)          quiet <= quiet - 1'b1;
    end
  end

  assert_req_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(br_out));

  assert_no_req_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    bbsy |-> (br_out == '0));

  assert_grant_to_busy_R2: assert property (@(posedge clk) disable iff (rst)
    ((br_out != '0) && bg_in) |=> bbsy);

  assert_hold_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (bbsy && (never_i || stay_i)) |=> bbsy);

  assert_done_release_R4: assert property (@(posedge clk) disable iff (rst)
    (bbsy && !never_i && !stay_i && rwd_i && loc_done) |=> !bbsy);

  assert_ror_release_R5: assert property (@(posedge clk) disable iff (rst)
    (bbsy && !never_i && !stay_i && !rwd_i && (br_others != '0)) |=> !bbsy);

  assert_holdoff_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (quiet != '0) |-> (br_out == '0));

endmodule

bind bus_requester_top bus_requester_checker #(
  .NUM_LEVELS(NUM_LEVELS),
  .QUIET_CYC (NEG_CYC + DRV_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .br_out   (br_out),
  .bbsy     (bbsy),
  .bg_in    (bg_in),
  .br_others(br_others),
  .loc_done (loc_done),
  .never_i  (policy_w.never),
  .stay_i   (policy_w.stay),
  .rwd_i    (policy_w.rwd),
  .wneg_i   (policy_w.wneg)
);

// File: tb/tb_bus_requester_top.sv
module tb_bus_requester_top;

  localparam int PERIOD_PS = 8000;
  localparam int NEG = (150000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int DRV = (200000 + PERIOD_PS - 1) / PERIOD_PS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       loc_req = 1'b0;
  logic       loc_done = 1'b0;
  logic       bg_in = 1'b0;
  logic [3:0] br_others = '0;
  logic [3:0] br_out;
  logic       bbsy;
  logic       have_bus;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  bus_requester_top #(.CLK_PERIOD_PS(PERIOD_PS)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .loc_req(loc_req), .loc_done(loc_done),
    .bg_in(bg_in), .br_others(br_others), .br_out(br_out),
    .bbsy(bbsy), .have_bus(have_bus)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] d);
    cfg_wdata = d; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic gain();
    bg_in = 1'b1; tick(1); bg_in = 1'b0;
  endtask

  task automatic pulse_done();
    loc_done = 1'b1; tick(1); loc_done = 1'b0;
  endtask

  initial begin
    int n;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(br_out == 0 && !bbsy && !have_bus, "R1 outputs idle", {br_out, bbsy, have_bus}, 0);
    check(cfg_rdata == 8'h03, "R1 readback", cfg_rdata, 8'h03);

    // R2/R3 sweep over every level
    for (int l = 0; l < 4; l++) begin
      write_cfg(8'h10 | 8'(l));
      loc_req = 1'b1; tick(2);
      gain(); loc_req = 1'b0;
      pulse_done(); tick(2);
      check(cfg_rdata[1:0] == 2'(l), "R3 level after release", cfg_rdata[1:0], l);
      loc_req = 1'b1; tick(1);
      check(br_out == 4'(1 << l), "R2 line for level", br_out, 1 << l);
      gain(); loc_req = 1'b0;
      check(bbsy && have_bus && br_out == 0, "R2 master after grant", {br_out, bbsy, have_bus}, 3);
      pulse_done(); tick(2);
    end

    // R3 lag, R4 release when done, R9 readback
    write_cfg(8'h11);
    check(cfg_rdata == 8'h13, "R3 R9 lagging level readback", cfg_rdata, 8'h13);
    loc_req = 1'b1; tick(4);
    check(br_out == 4'b1000 && !bbsy, "R2 request held without grant", br_out, 4'b1000);
    gain(); loc_req = 1'b0;
    check(cfg_rdata == 8'h53, "R9 have bit set", cfg_rdata, 8'h53);
    br_others = 4'b0010; tick(2); br_others = '0;
    check(bbsy == 1'b1, "R4 other request ignored", bbsy, 1);
    pulse_done();
    check(bbsy == 1'b0, "R4 release after done", bbsy, 0);
    tick(2);
    check(cfg_rdata == 8'h11, "R3 new level active", cfg_rdata, 8'h11);
    loc_req = 1'b1; tick(1);
    check(br_out == 4'b0010, "R3 new line used", br_out, 4'b0010);
    gain(); loc_req = 1'b0; pulse_done(); tick(2);

    // R5 release on request
    write_cfg(8'h01);
    loc_req = 1'b1; tick(1); gain(); loc_req = 1'b0;
    loc_done = 1'b1; tick(2); loc_done = 1'b0;
    check(bbsy == 1'b1, "R5 done ignored", bbsy, 1);
    br_others = 4'b0100; tick(1); br_others = '0;
    check(bbsy == 1'b0, "R5 release on other request", bbsy, 0);
    tick(2);

    // R6 never release
    write_cfg(8'h18);
    check(cfg_rdata == 8'h19, "R9 R6 readback", cfg_rdata, 8'h19);
    tick(10);
    check(br_out == 0, "R6 no request by itself", br_out, 0);
    loc_req = 1'b1; tick(1);
    check(br_out == 4'b0010, "R6 request from local", br_out, 4'b0010);
    gain(); loc_req = 1'b0;
    loc_done = 1'b1; tick(2); loc_done = 1'b0;
    br_others = 4'b1111; tick(2); br_others = '0;
    check(bbsy == 1'b1, "R6 held despite done and requests", bbsy, 1);
    write_cfg(8'h10);
    check(bbsy == 1'b1, "R6 policy waits for done", bbsy, 1);
    pulse_done();
    check(bbsy == 1'b0, "R6 released after clear", bbsy, 0);
    tick(2);
    check(cfg_rdata[1:0] == 2'd0, "R3 level zero active", cfg_rdata[1:0], 0);

    // R7 stay on bus
    write_cfg(8'h80);
    tick(1);
    check(br_out == 4'b0001, "R7 request without local", br_out, 4'b0001);
    gain();
    loc_done = 1'b1; br_others = 4'b0110; tick(3); loc_done = 1'b0; br_others = '0;
    check(bbsy == 1'b1, "R7 held", bbsy, 1);
    write_cfg(8'h88); write_cfg(8'h08);
    br_others = 4'b0010; tick(2); br_others = '0;
    check(bbsy == 1'b1, "R7 held by bit 3 alone", bbsy, 1);
    write_cfg(8'h00);
    br_others = 4'b0010; tick(1); br_others = '0;
    check(bbsy == 1'b0, "R7 released when both clear", bbsy, 0);
    tick(4);
    check(br_out == 0, "R7 no re-request after clear", br_out, 0);

    // R8 hold-off window
    write_cfg(8'h30);
    loc_req = 1'b1; tick(1); gain();
    br_others = 4'b0001;
    pulse_done();
    tick(60);
    check(br_out == 0, "R8 no request while line high", br_out, 0);
    br_others = '0;
    n = 0;
    while (br_out == 0 && n < 200) begin tick(1); n++; end
    check(n >= NEG + DRV && n <= NEG + DRV + 4, "R8 hold-off cycles", n, NEG + DRV + 1);
    gain();
    write_cfg(8'h10);
    pulse_done();
    n = 0;
    while (br_out == 0 && n < 200) begin tick(1); n++; end
    check(n == 2, "R8 quick re-request without bit 5", n, 2);
    gain(); loc_req = 1'b0; pulse_done(); tick(3);
    check(br_out == 0 && !bbsy, "R10 quiet at end", {br_out, bbsy}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1-chain actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule